// File: doc/BRIEF.md
# Serial Rate Change Handshake Controller

This block sits in the user clock domain beside a serial link and manages requests to change the serial-clock divider. A 3-bit rate request is decoded either into a fixed power-of-two divider (1, 2, 4 or 8) or into a separately supplied default divider value. Any accepted change of the request updates the active divider at once. It also raises a busy flag and starts a programmable settling delay. When the delay runs out, a single-cycle done pulse is given.

The request can come from logic clocked by the user clock (synchronous mode) or from elsewhere (asynchronous mode). In asynchronous mode the request passes through a two-flop synchronizer. A new value is accepted only once it has been seen unchanged on two consecutive samples, so a skewed multi-bit transition is never acted on. A further change while the delay is running restarts the delay. Only one done pulse follows, and it belongs to the final value.

Top module: `rate_switch_ctrl`

## Requirements
- R1: Request codes 3'b001, 3'b010, 3'b011 and 3'b100 set `div_out` to the binary divider values 1, 2, 4 and 8 respectively when the change is accepted.
- R2: Request code 3'b000 sets `div_out` to the value on `dflt_div` captured in the cycle the change is accepted; later changes of `dflt_div` do not affect `div_out` until another change is accepted.
- R3: Reserved codes 3'b101, 3'b110 and 3'b111 leave `div_out` unchanged but still raise `busy` and produce a done pulse.
- R4: In synchronous mode, a request driven before clock edge n is accepted at edge n+1. Here `div_out` and `busy` update. `done` is high for exactly one cycle, SETTLE+1 cycles after `busy` rises.
- R5: `busy` is high from the accepting edge until the done pulse. It is low in the done cycle, and it falls only together with a done pulse.
- R6: A request change accepted while `busy` is high reloads the delay, updates `div_out` and emits one done pulse only, timed from the last change. This holds when the new change lands in the cycle the old delay would have expired.
- R7: With `req_async` high, the request is accepted two edges later than in synchronous mode, and only after two consecutive equal synchronized samples. A code held for a single cycle is never applied. Toggling `req_async` while the request is steady has no effect.
- R8: During reset `div_out` is 1 and `busy` and `done` are 0. After reset the current request becomes the baseline divider with no busy and no done pulse.
- R9: With SETTLE = 0, `done` rises in the cycle right after the accepting edge, and `busy` is high for that single cycle.
- R10: `div_out` changes only at an accepting edge; between accepted changes it is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_req | input | CODE_W | Requested rate code |
| req_async | input | 1 | High when rate_req is not synchronous to clk |
| dflt_div | input | DIV_W | Divider value applied for code 3'b000 |
| div_out | output | DIV_W | Active divider value |
| busy | output | 1 | Rate transition in progress |
| done | output | 1 | One-cycle pulse at the end of a transition |

## Verification
A wrong settle count shows as a done pulse that is early or late relative to the rise of busy. This appears within SETTLE+2 cycles of the change. A stale baseline code shows as a missing or spurious busy and done at the next request edit, or as a done pulse right after reset. A sampler that accepts unsettled values shows as a brief wrong divider value or an extra done pulse a few cycles after a one-cycle request glitch in asynchronous mode. Every transition is therefore checked cycle by cycle from the drive of the request until one cycle past the expected pulse.

// File: rtl/rate_pkg.sv
package rate_pkg;

    // Number of valid samples held by the request sampler since reset.
    typedef enum logic [1:0] {
        FILL_NONE = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_TWO  = 2'd2,
        FILL_FULL = 2'd3
    } fill_e;

    function automatic fill_e fill_next(fill_e f);
        case (f)
            FILL_NONE: return FILL_ONE;
            FILL_ONE:  return FILL_TWO;
            default:   return FILL_FULL;
        endcase
    endfunction

endpackage

// File: rtl/rate_req_sampler.sv
module rate_req_sampler
    import rate_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_async,
    input  logic [CODE_W-1:0] req_in,
    output logic [CODE_W-1:0] cand,
    output logic              cand_vld
);

    typedef struct packed {
        logic [CODE_W-1:0] s1;
        logic [CODE_W-1:0] s2;
        logic [CODE_W-1:0] s3;
        fill_e             fill;
    } smp_t;

    smp_t smp_q, smp_d;

    always_comb begin
        smp_d      = smp_q;
        smp_d.s1   = req_in;
        smp_d.s2   = smp_q.s1;
        smp_d.s3   = smp_q.s2;
        smp_d.fill = fill_next(smp_q.fill);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    // Synchronous mode: one capture stage is enough.
    // Asynchronous mode: two synchronizer stages plus a stability compare.
    always_comb begin
        if (req_async) begin
            cand     = smp_q.s2;
            cand_vld = (smp_q.fill == FILL_FULL) && (smp_q.s2 == smp_q.s3);
        end else begin
            cand     = smp_q.s1;
            cand_vld = (smp_q.fill != FILL_NONE);
        end
    end

endmodule

// File: rtl/rate_code_decoder.sv
module rate_code_decoder #(
    parameter int CODE_W = 3,
    parameter int DIV_W  = 4,
    parameter int N_POW  = 4
) (
    input  logic [CODE_W-1:0] code,
    input  logic [DIV_W-1:0]  dflt,
    output logic [DIV_W-1:0]  div,
    output logic              keep
);

    localparam int TOP_CODE = N_POW;

    always_comb begin
        div  = dflt;
        keep = 1'b1;
        if (code == '0) begin
            keep = 1'b0;
        end
        for (int k = 1; k <= TOP_CODE; k++) begin
            if (code == CODE_W'(k)) begin
                div  = DIV_W'(1) << (k - 1);
                keep = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rate_settle_ctrl.sv
module rate_settle_ctrl #(
    parameter int CODE_W = 3,
    parameter int DIV_W  = 4,
    parameter int SETTLE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cand,
    input  logic              cand_vld,
    input  logic [DIV_W-1:0]  dec_div,
    input  logic              dec_keep,
    output logic [DIV_W-1:0]  div_out,
    output logic              busy,
    output logic              done,
    output logic              seeded
);

    localparam int CNT_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

    typedef struct packed {
        logic [CODE_W-1:0] cur;
        logic [DIV_W-1:0]  div;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              done;
        logic              seeded;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        cur:    '0,
        div:    DIV_W'(1),
        cnt:    '0,
        busy:   1'b0,
        done:   1'b0,
        seeded: 1'b0
    };

    ctl_t ctl_q, ctl_d;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (!ctl_q.seeded) begin
            // First valid sample after reset becomes the baseline.
            if (cand_vld) begin
                ctl_d.seeded = 1'b1;
                ctl_d.cur    = cand;
                if (!dec_keep) begin
                    ctl_d.div = dec_div;
                end
            end
        end else if (cand_vld && (cand != ctl_q.cur)) begin
            // New or restarted transition; a change wins over expiry.
            ctl_d.cur  = cand;
            ctl_d.busy = 1'b1;
            ctl_d.cnt  = CNT_W'(SETTLE);
            if (!dec_keep) begin
                ctl_d.div = dec_div;
            end
        end else if (ctl_q.busy) begin
            if (ctl_q.cnt == '0) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end else begin
                ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign div_out = ctl_q.div;
    assign busy    = ctl_q.busy;
    assign done    = ctl_q.done;
    assign seeded  = ctl_q.seeded;

endmodule

// File: rtl/rate_switch_ctrl.sv
module rate_switch_ctrl #(
    parameter int CODE_W = 3,
    parameter int DIV_W  = 4,
    parameter int N_POW  = 4,
    parameter int SETTLE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rate_req,
    input  logic              req_async,
    input  logic [DIV_W-1:0]  dflt_div,
    output logic [DIV_W-1:0]  div_out,
    output logic              busy,
    output logic              done
);

    logic [CODE_W-1:0] cand;
    logic              cand_vld;
    logic [DIV_W-1:0]  dec_div;
    logic              dec_keep;
    logic              seeded;

    rate_req_sampler #(
        .CODE_W (CODE_W)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (req_async),
        .req_in    (rate_req),
        .cand      (cand),
        .cand_vld  (cand_vld)
    );

    rate_code_decoder #(
        .CODE_W (CODE_W),
        .DIV_W  (DIV_W),
        .N_POW  (N_POW)
    ) u_decoder (
        .code (cand),
        .dflt (dflt_div),
        .div  (dec_div),
        .keep (dec_keep)
    );

    rate_settle_ctrl #(
        .CODE_W (CODE_W),
        .DIV_W  (DIV_W),
        .SETTLE (SETTLE)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (cand),
        .cand_vld (cand_vld),
        .dec_div  (dec_div),
        .dec_keep (dec_keep),
        .div_out  (div_out),
        .busy     (busy),
        .done     (done),
        .seeded   (seeded)
    );

endmodule

// File: rtl/rate_switch_ctrl_chk.sv
module rate_switch_ctrl_chk #(
    parameter int DIV_W  = 4,
    parameter int SETTLE = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_out,
    input logic             busy,
    input logic             done,
    input logic             seeded
);

    int run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4
    settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q >= SETTLE + 1));

    // R10
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seeded && $past(seeded) && (div_out != $past(div_out))) |-> busy);

endmodule

bind rate_switch_ctrl rate_switch_ctrl_chk #(
    .DIV_W  (DIV_W),
    .SETTLE (SETTLE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_out (div_out),
    .busy    (busy),
    .done    (done),
    .seeded  (seeded)
);

// File: tb/tb_rate_switch_ctrl.sv
`timescale 1ns/1ps
module tb_rate_switch_ctrl;

    localparam int CODE_W = 3;
    localparam int DIV_W  = 4;
    localparam int SET_A  = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CODE_W-1:0] rate_req;
    logic              req_async;
    logic [DIV_W-1:0]  dflt_div;
    logic [DIV_W-1:0]  div_a, div_z;
    logic              busy_a, busy_z, done_a, done_z;

    always #2 clk = ~clk;

    rate_switch_ctrl #(.CODE_W(CODE_W), .DIV_W(DIV_W), .N_POW(4), .SETTLE(SET_A)) dut (
        .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .req_async(req_async),
        .dflt_div(dflt_div), .div_out(div_a), .busy(busy_a), .done(done_a));

    rate_switch_ctrl #(.CODE_W(CODE_W), .DIV_W(DIV_W), .N_POW(4), .SETTLE(0)) dut_z (
        .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .req_async(req_async),
        .dflt_div(dflt_div), .div_out(div_z), .busy(busy_z), .done(done_z));

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [DIV_W-1:0]  model_div;
    logic [CODE_W-1:0] cur_code;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic logic [DIV_W-1:0] exp_div(logic [CODE_W-1:0] c,
                                                 logic [DIV_W-1:0] prev,
                                                 logic [DIV_W-1:0] dflt);
        if (c == 3'd0) return dflt;
        if (c >= 3'd1 && c <= 3'd4) return DIV_W'(1) << (c - 3'd1);
        return prev;
    endfunction

    // Called at a negedge; drives a new code and checks every following cycle.
    task automatic step(logic [CODE_W-1:0] code);
        int lat;
        logic [DIV_W-1:0] nd;
        string rt;
        lat = req_async ? 4 : 2;
        nd  = exp_div(code, model_div, dflt_div);
        rt  = (code == 3'd0) ? "R2" : ((code <= 3'd4) ? "R1" : "R3");
        rate_req = code;
        for (int k = 1; k <= lat + SET_A + 2; k++) begin
            @(negedge clk);
            if (k < lat) chk("R10 div before accept", int'(div_a), int'(model_div));
            else         chk({rt, " div"}, int'(div_a), int'(nd));
            chk("R5 busy", int'(busy_a), int'(k >= lat && k <= lat + SET_A));
            chk("R4 done", int'(done_a), int'(k == lat + SET_A + 1));
            chk("R9 busy", int'(busy_z), int'(k == lat));
            chk("R9 done", int'(done_z), int'(k == lat + 1));
            chk("R9 div", int'(div_z), int'((k < lat) ? model_div : nd));
        end
        model_div = nd;
        cur_code  = code;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        int ndone;
        int first;
        bit saw_two;
        rst_n     = 1'b0;
        rate_req  = 3'b011;
        req_async = 1'b0;
        dflt_div  = 4'd6;
        repeat (3) @(negedge clk);
        chk("R8 reset div", int'(div_a), 1);
        chk("R8 reset busy", int'(busy_a), 0);
        chk("R8 reset done", int'(done_a), 0);
        chk("R8 reset div z", int'(div_z), 1);
        rst_n = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk("R8 no busy after reset", int'(busy_a | busy_z), 0);
            chk("R8 no done after reset", int'(done_a | done_z), 0);
        end
        chk("R8 baseline div", int'(div_a), 4);
        chk("R8 baseline div z", int'(div_z), 4);
        model_div = 4'd4;
        cur_code  = 3'b011;

        // Synchronous sweep over every ordered pair of codes.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (a != b) begin
                    if (cur_code != 3'(a)) step(3'(a));
                    step(3'(b));
                end
            end
        end

        // R2: default captured at accept time only.
        if (cur_code != 3'd0) step(3'd0);
        dflt_div = 4'd9;
        repeat (6) begin
            @(negedge clk);
            chk("R2 default change ignored div", int'(div_a), 6);
            chk("R2 default change no busy", int'(busy_a), 0);
        end
        step(3'd1);
        step(3'd0);
        chk("R2 new default applied", int'(div_a), 9);

        // R6: restart landing on the expiry cycle.
        if (cur_code != 3'd4) step(3'd4);
        ndone = 0;
        first = 0;
        rate_req = 3'd1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (done_a) ndone++;
            if (k >= 2) chk("R6 first code div", int'(div_a), 1);
        end
        rate_req = 3'd2;
        for (int j = 1; j <= 12; j++) begin
            @(negedge clk);
            if (done_a) begin
                ndone++;
                if (first == 0) first = j;
            end
        end
        chk("R6 single done", ndone, 1);
        chk("R6 done timing", first, 2 + SET_A + 1);
        chk("R6 final div", int'(div_a), 2);
        model_div = 4'd2;
        cur_code  = 3'd2;

        // R7: switch to asynchronous mode with a steady request.
        req_async = 1'b1;
        repeat (6) begin
            @(negedge clk);
            chk("R7 mode switch no busy", int'(busy_a | busy_z), 0);
            chk("R7 mode switch no done", int'(done_a | done_z), 0);
            chk("R7 mode switch div", int'(div_a), 2);
        end
        for (int c = 0; c < 8; c++) begin
            if (cur_code != 3'(c)) step(3'(c));
        end

        // R7: a one-cycle code is never applied.
        if (cur_code != 3'd1) step(3'd1);
        ndone   = 0;
        first   = 0;
        saw_two = 1'b0;
        rate_req = 3'd2;
        @(negedge clk);
        if (div_a == 4'd2) saw_two = 1'b1;
        rate_req = 3'd3;
        for (int j = 2; j <= 13; j++) begin
            @(negedge clk);
            if (div_a == 4'd2) saw_two = 1'b1;
            if (done_a) begin
                ndone++;
                if (first == 0) first = j;
            end
        end
        chk("R7 glitch code never applied", int'(saw_two), 0);
        chk("R7 single done", ndone, 1);
        chk("R7 done timing", first, 9);
        chk("R7 final div", int'(div_a), 4);

        finished = 1;
        report();
        $finish;
    end

endmodule